// File: doc/BRIEF.md
# Fractional-rate timestamp clock with transmit and receive snapshots

This block keeps a 64-bit hardware time count for precision time protocol use. The count does not follow the system clock directly. A 32-bit accumulator adds a programmed addend on every system clock while the unit is enabled, and each carry out of the accumulator advances the time by one count. With an addend of 25,000,000 × 2^32 / f_clk, the count advances at an average of 25 MHz, so one count stands for 40 ns whatever the system clock frequency.

Software reaches the block through a small register port. It programs the addend, sets or reads the time as two 32-bit words, and turns the unit on and off. Reading the low time word freezes a copy of the high word, so a following high-word read gives a coherent 64-bit value.

When the transmit side or the receive side reports the start of an event frame, the block captures the current time into a snapshot pair for that direction and raises a valid flag. The flag blocks any further capture in that direction until software reads the snapshot's high word. An unread timestamp is therefore never overwritten. The register port, the strobes and the flags are plain single-cycle signals with no handshake.

Top module: `ptp_stamp_clock`

## Requirements
- R1: After reset, every register reads 0, the accumulator is 0, and both tx_stamp_valid and rx_stamp_valid are low.
- R2: Register map on reg_addr: 0 control (bit 0 = enable, other bits read 0), 1 addend, 2 time low, 3 time high, 4 transmit snapshot low, 5 transmit snapshot high, 6 receive snapshot low, 7 receive snapshot high. A read strobed in one cycle drives its value on reg_rdata from the next cycle, and that value holds until the next read. A write takes effect from the next cycle.
- R3: While enabled, the accumulator adds the addend modulo 2^32 on every cycle. On a cycle with a carry out, the time grows by one. On a cycle without a carry, the time holds.
- R4: The time count wraps from all ones to zero.
- R5: While enable is 0, the accumulator and the time hold their values and no snapshot is taken. Register writes and reads still take effect.
- R6: A write to time low or time high replaces that half from the next cycle and leaves the other half unchanged. No increment is applied in that cycle.
- R7: Reading time low returns the low half and copies the current high half into a shadow. Reading time high returns the shadow.
- R8: When enabled and tx_stamp_valid is low, tx_sof together with tx_event captures the time value of that cycle, taken before that cycle's increment, into the transmit snapshot. tx_stamp_valid rises in the next cycle.
- R9: The receive side behaves in the same way with rx_sof, rx_event, the receive snapshot and rx_stamp_valid.
- R10: A start-of-frame strobe without its event qualifier is ignored.
- R11: While a valid flag is high, further strobes for that direction are ignored, and the snapshot keeps its first value.
- R12: Reading a snapshot high word returns the high half and clears that direction's flag. Reading a snapshot low word leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_event | input | 1 | Transmit frame is an event message |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_event | input | 1 | Receive frame qualifies for stamping |
| tx_stamp_valid | output | 1 | Transmit snapshot held and unread |
| rx_stamp_valid | output | 1 | Receive snapshot held and unread |

## Verification
The bench runs the count across its 64-bit wrap, using an addend near all ones so that carries come almost every cycle. A design with a broken carry into the high word would show a wrong high half after the wrap. It fires strobes while a flag is already set, and in the same cycle as the clearing high-word read. A design that overwrote an unread stamp, or that cleared the flag on a low-word read, would return a later time or drop the flag too early. It also pairs each time-low read with a time-high read across increments and direct writes. A design without the shadow would return a torn 64-bit value. Finally, it checks that a disabled unit freezes both the time and the flags, and that a strobe without its qualifier leaves the snapshot untouched.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_ADDEND  = 3'd1,
    REG_TIME_LO = 3'd2,
    REG_TIME_HI = 3'd3,
    REG_TXS_LO  = 3'd4,
    REG_TXS_HI  = 3'd5,
    REG_RXS_LO  = 3'd6,
    REG_RXS_HI  = 3'd7
  } reg_sel_e;

  localparam int N_DIR  = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
endpackage

// File: rtl/ptp_addend_accum.sv
module ptp_addend_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] addend_o,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend_q;
  logic [ACC_W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, addend_q};
  assign tick     = enable & sum[ACC_W];
  assign addend_o = addend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      if (load)   addend_q <= load_val;
      if (enable) acc_q    <= sum[ACC_W-1:0];
    end
  end

  // R5: a disabled unit leaves the phase accumulator untouched
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(acc_q));

  // R3: a zero addend never produces a carry
  a_r3_zero_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_q == '0) |-> !tick);
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                rd_lo,
  output logic [2*WORD_W-1:0] time_o,
  output logic [WORD_W-1:0]   shadow_o
);
  localparam int TIME_W = 2 * WORD_W;

  logic [TIME_W-1:0] time_q;
  logic [WORD_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_lo || wr_hi) begin
        if (wr_lo) time_q[WORD_W-1:0]      <= wdata;
        if (wr_hi) time_q[TIME_W-1:WORD_W] <= wdata;
      end else if (tick) begin
        time_q <= time_q + 1'b1;
      end
      if (rd_lo) shadow_q <= time_q[TIME_W-1:WORD_W];
    end
  end

  assign time_o   = time_o_int();
  assign shadow_o = shadow_q;

  function automatic logic [TIME_W-1:0] time_o_int();
    return time_q;
  endfunction

  // R3: without a carry or a write the time holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(time_q));

  // R4: an all-ones count wraps to zero on the next carry
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q == {TIME_W{1'b1}} && tick && !wr_lo && !wr_hi) |=> (time_q == '0));

  // R6: a low-word write leaves the high half alone
  a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (time_q[TIME_W-1:WORD_W] == $past(time_q[TIME_W-1:WORD_W])));

  // R7: the shadow tracks the high half seen at the low-word read
  a_r7_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow_q == $past(time_q[TIME_W-1:WORD_W])));
endmodule

// File: rtl/ptp_snapshot.sv
module ptp_snapshot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sof,
  input  logic              event_i,
  input  logic [TIME_W-1:0] now,
  input  logic              rd_hi,
  output logic [TIME_W-1:0] snap_o,
  output logic              valid_o
);
  logic [TIME_W-1:0] snap_q;
  logic              valid_q;
  logic              capture;

  assign capture = enable & sof & event_i & ~valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (capture) begin
        snap_q  <= now;
        valid_q <= 1'b1;
      end else if (rd_hi) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = valid_q;

  // R11: an unread stamp keeps its value and its flag
  a_r11_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_hi) |=> (valid_q && $stable(snap_q)));

  // R8: the flag only rises after a qualified, enabled strobe
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(sof && event_i && enable));

  // R5: no capture while disabled
  a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(snap_q));

  // R12: a high-word read of a held stamp clears the flag
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rd_hi) |=> !valid_q);
endmodule

// File: rtl/ptp_stamp_clock.sv
module ptp_stamp_clock
  import ptp_clk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  input  logic                  tx_sof,
  input  logic                  tx_event,
  input  logic                  rx_sof,
  input  logic                  rx_event,
  output logic                  tx_stamp_valid,
  output logic                  rx_stamp_valid
);
  localparam int TIME_W = 2 * WORD_W;

  reg_sel_e          sel;
  logic              enable_q;
  logic              tick;
  logic [WORD_W-1:0] addend;
  logic [TIME_W-1:0] now;
  logic [WORD_W-1:0] shadow;
  logic [WORD_W-1:0] rdata_q;

  logic [N_DIR-1:0]  sof_v;
  logic [N_DIR-1:0]  evt_v;
  logic [N_DIR-1:0]  rdhi_v;
  logic [N_DIR-1:0]  valid_v;
  logic [TIME_W-1:0] snap_v [N_DIR];

  assign sel = reg_sel_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= 1'b0;
    else if (reg_wr && sel == REG_CTRL) enable_q <= reg_wdata[0];
  end

  ptp_addend_accum #(.ACC_W(WORD_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable_q),
    .load     (reg_wr && sel == REG_ADDEND),
    .load_val (reg_wdata),
    .addend_o (addend),
    .tick     (tick)
  );

  ptp_time_counter #(.WORD_W(WORD_W)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_lo    (reg_wr && sel == REG_TIME_LO),
    .wr_hi    (reg_wr && sel == REG_TIME_HI),
    .wdata    (reg_wdata),
    .rd_lo    (reg_rd && sel == REG_TIME_LO),
    .time_o   (now),
    .shadow_o (shadow)
  );

  assign sof_v[DIR_TX]  = tx_sof;
  assign evt_v[DIR_TX]  = tx_event;
  assign rdhi_v[DIR_TX] = reg_rd && sel == REG_TXS_HI;
  assign sof_v[DIR_RX]  = rx_sof;
  assign evt_v[DIR_RX]  = rx_event;
  assign rdhi_v[DIR_RX] = reg_rd && sel == REG_RXS_HI;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ptp_snapshot #(.TIME_W(TIME_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable_q),
      .sof     (sof_v[d]),
      .event_i (evt_v[d]),
      .now     (now),
      .rd_hi   (rdhi_v[d]),
      .snap_o  (snap_v[d]),
      .valid_o (valid_v[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (sel)
        REG_CTRL:    rdata_q <= {{(WORD_W-1){1'b0}}, enable_q};
        REG_ADDEND:  rdata_q <= addend;
        REG_TIME_LO: rdata_q <= now[WORD_W-1:0];
        REG_TIME_HI: rdata_q <= shadow;
        REG_TXS_LO:  rdata_q <= snap_v[DIR_TX][WORD_W-1:0];
        REG_TXS_HI:  rdata_q <= snap_v[DIR_TX][TIME_W-1:WORD_W];
        REG_RXS_LO:  rdata_q <= snap_v[DIR_RX][WORD_W-1:0];
        REG_RXS_HI:  rdata_q <= snap_v[DIR_RX][TIME_W-1:WORD_W];
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata      = rdata_q;
  assign tx_stamp_valid = valid_v[DIR_TX];
  assign rx_stamp_valid = valid_v[DIR_RX];

  // R2: read data only moves after a read strobe
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_ptp_stamp_clock.sv
module tb_ptp_stamp_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_sof = 1'b0, tx_event = 1'b0, rx_sof = 1'b0, rx_event = 1'b0;
  logic        tx_stamp_valid, rx_stamp_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptp_stamp_clock dut (.*);

  // reference state built from the requirements
  logic        m_en = 0;
  logic [31:0] m_add = 0, m_acc = 0, m_shadow = 0, m_rdata = 0;
  logic [63:0] m_time = 0, m_txs = 0, m_rxs = 0;
  logic        m_txf = 0, m_rxf = 0;

  always @(posedge clk) begin
    logic [32:0] s;
    logic [63:0] t0;
    logic        txf0, rxf0;
    if (!rst_n) begin
      m_en = 0; m_add = 0; m_acc = 0; m_shadow = 0; m_rdata = 0;
      m_time = 0; m_txs = 0; m_rxs = 0; m_txf = 0; m_rxf = 0;
    end else begin
      t0 = m_time; txf0 = m_txf; rxf0 = m_rxf;
      s = {1'b0, m_acc} + {1'b0, m_add};
      if (reg_rd) begin
        case (reg_addr)
          3'd0: m_rdata = {31'd0, m_en};
          3'd1: m_rdata = m_add;
          3'd2: begin m_rdata = t0[31:0]; m_shadow = t0[63:32]; end
          3'd3: m_rdata = m_shadow;
          3'd4: m_rdata = m_txs[31:0];
          3'd5: begin m_rdata = m_txs[63:32]; m_txf = 0; end
          3'd6: m_rdata = m_rxs[31:0];
          default: begin m_rdata = m_rxs[63:32]; m_rxf = 0; end
        endcase
      end
      if (m_en && tx_sof && tx_event && !txf0) begin m_txs = t0; m_txf = 1; end
      if (m_en && rx_sof && rx_event && !rxf0) begin m_rxs = t0; m_rxf = 1; end
      if (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) begin
        if (reg_addr == 3'd2) m_time[31:0]  = reg_wdata;
        else                  m_time[63:32] = reg_wdata;
      end else if (m_en && s[32]) begin
        m_time = t0 + 64'd1;
      end
      if (m_en) m_acc = s[31:0];
      if (reg_wr && reg_addr == 3'd0) m_en = reg_wdata[0];
      if (reg_wr && reg_addr == 3'd1) m_add = reg_wdata;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(bit wr, bit rd, logic [2:0] a, logic [31:0] d,
                    bit ts, bit te, bit rs, bit re);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    tx_sof = ts; tx_event = te; rx_sof = rs; rx_event = re;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; tx_sof = 0; tx_event = 0; rx_sof = 0; rx_event = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    op(1, 0, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    op(0, 1, a, 0, 0, 0, 0, 0);
    check(tag, {32'd0, reg_rdata}, {32'd0, m_rdata});
  endtask

  task automatic flags(string tag);
    check(tag, {62'd0, tx_stamp_valid, rx_stamp_valid}, {62'd0, m_txf, m_rxf});
  endtask

  task automatic idle(int n);
    repeat (n) op(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    logic [31:0] lo0, hi0, v;
    void'($urandom(32'd1588));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    flags("R1 flags");
    for (int a = 0; a < 8; a++) begin
      op(0, 1, a[2:0], 0, 0, 0, 0, 0);
      check("R1 reset read", {32'd0, reg_rdata}, 64'd0);
    end
    // R2: register map readback
    wr(3'd1, 32'h8000_0000, "R2");
    rd(3'd1, "R2 addend readback");
    wr(3'd0, 32'hFFFF_FFFF, "R2");
    rd(3'd0, "R2 control reads only enable");
    // R3: half-rate counting
    idle(20);
    rd(3'd2, "R3 time lo");
    rd(3'd3, "R3 time hi");
    // R4: wrap through all ones, near-every-cycle carry
    wr(3'd1, 32'hFFFF_FFFF, "R4");
    wr(3'd3, 32'hFFFF_FFFF, "R4");
    wr(3'd2, 32'hFFFF_FFFE, "R4");
    idle(10);
    rd(3'd2, "R4 wrapped lo");
    rd(3'd3, "R4 wrapped hi");
    check("R4 high half is zero after wrap", {32'd0, reg_rdata}, 64'd0);
    // R6: writes replace one half
    wr(3'd3, 32'h00AB_CDEF, "R6");
    rd(3'd2, "R6 lo"); rd(3'd3, "R6 hi");
    // R7: coherent pair across a low-word rollover
    wr(3'd2, 32'hFFFF_FFFD, "R7");
    op(0, 1, 3'd2, 0, 0, 0, 0, 0); lo0 = reg_rdata;
    check("R7 time lo", {32'd0, lo0}, {32'd0, m_rdata});
    idle(6);
    rd(3'd3, "R7 shadow hi");
    // R5: disabled unit freezes
    wr(3'd0, 0, "R5");
    rd(3'd2, "R5 lo a"); v = reg_rdata;
    idle(8);
    op(1, 0, 3'd1, 32'h1234_5678, 1, 1, 1, 1);
    flags("R5 no capture while disabled");
    rd(3'd2, "R5 lo b");
    check("R5 time frozen", {32'd0, reg_rdata}, {32'd0, v});
    rd(3'd1, "R5 addend written while off");
    // R8 / R11 / R12 transmit
    wr(3'd1, 32'h4000_0000, "R8");
    wr(3'd0, 1, "R8");
    idle(3);
    op(0, 0, 0, 0, 1, 1, 0, 0);
    flags("R8 tx flag set");
    check("R8 tx flag", {63'd0, tx_stamp_valid}, 64'd1);
    idle(5);
    op(0, 0, 0, 0, 1, 1, 0, 0);
    rd(3'd4, "R11 tx lo kept");
    flags("R12 lo read keeps flag");
    rd(3'd5, "R12 tx hi");
    flags("R12 hi read clears flag");
    // R9 receive, strobe together with clearing read
    op(0, 0, 0, 0, 0, 0, 1, 1);
    flags("R9 rx flag set");
    idle(4);
    op(0, 1, 3'd7, 0, 0, 0, 1, 1);
    check("R11 rx hi while held", {32'd0, reg_rdata}, {32'd0, m_rdata});
    flags("R12 rx cleared, coincident strobe ignored");
    rd(3'd6, "R9 rx lo");
    // R10: unqualified strobes
    op(0, 0, 0, 0, 1, 0, 1, 0);
    flags("R10 unqualified ignored");
    check("R10 rx flag low", {63'd0, rx_stamp_valid}, 64'd0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: wr(3'd1, $urandom, "R3 rnd addend");
        1: wr(3'd0, {31'd0, ($urandom_range(0, 5) != 0)}, "R5 rnd en");
        2: wr(3'd2, ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFF0 : $urandom, "R6 rnd lo");
        3: wr(3'd3, ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom, "R6 rnd hi");
        4, 5: rd($urandom_range(2, 7), "R7 rnd read");
        6: rd($urandom_range(0, 1), "R2 rnd read");
        default: op(0, 0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1));
      endcase
      flags("R11 rnd flags");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule